// File: doc/BRIEF.md
# Time-Multiplexed Euler Integrator

This block integrates several independent signals with the forward Euler rule while owning only one multiplier and one adder. The signals share a single input port. Their derivative samples arrive interleaved, at most one per clock, in a fixed rotating channel order. Each accepted sample is multiplied by a fixed step coefficient. The product is added to that channel's running value. The running value comes back to the adder through a recirculating delay line with one word per channel, so the adder sees each channel's previous result exactly when that channel's next sample arrives.

Every channel has its own output register. It changes only when its channel is integrated or preloaded, and it holds its value otherwise. The arithmetic is signed fixed point. The accumulator is wider than the input sample and clamps on overflow instead of wrapping. A preload port seeds any channel's stored value before or between integration runs. An index that breaks the rotation is rejected and flagged. With the default parameters, a 250 MHz clock and four channels give each channel an update every 16 ns.

Top module: `tm_euler_integrator`

## Requirements
- R1: A synchronous active-high reset clears every channel output, the stored channel values, the update strobes and the sequence-error flag, and it makes channel 0 the next expected index. A sample in flight when reset is asserted is discarded.
- R2: A sample is accepted when `in_valid` is high, `preload_en` is low and `in_chan` equals the expected index. The expected index then advances 0, 1, …, NCH-1, wraps to 0, and does not move on idle cycles.
- R3: The scaled increment of a sample d is floor(d × STEP_COEF / 2^STEP_FRAC), with STEP_COEF = 20 and STEP_FRAC = 4 by default, so 7 gives 8 and -7 gives -9.
- R4: A sample accepted at clock edge k updates `ch_out[c]` at edge k+1 to the previous value of channel c plus the scaled increment. During the following cycle, `ch_upd` has only bit c set.
- R5: A channel that is neither integrated nor preloaded keeps its output value unchanged, and `ch_upd` never has more than one bit set.
- R6: A sum above 2^(ACC_W-1)-1 gives exactly that maximum, and a sum below -2^(ACC_W-1) gives exactly that minimum (8388607 and -8388608 for ACC_W = 24).
- R7: A valid sample whose index differs from the expected one, presented while `preload_en` is low, is discarded without changing any channel or the expected index. `seq_err` is then high for exactly the next cycle, and it is low after every other cycle.
- R8: With `preload_en` high, `preload_data` is written to the stored value and the output of channel `preload_chan` at the next edge. A preload wins over an integration result for the same channel at the same edge, and that channel's `ch_upd` bit stays low.
- R9: While `preload_en` is high, input samples are ignored: they raise no error and do not move the expected index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Derivative sample present |
| in_chan | input | CH_W | Channel index of the sample |
| in_data | input | IN_W | Signed derivative sample |
| preload_en | input | 1 | Write a seed value this cycle |
| preload_chan | input | CH_W | Channel to seed |
| preload_data | input | ACC_W | Signed seed value |
| ch_out | output | NCH×ACC_W | Per-channel integrated values, channel c in slice c |
| ch_upd | output | NCH | One-cycle strobe marking the channel integrated at the last edge |
| seq_err | output | 1 | One-cycle flag for a rejected out-of-order index |

## Verification
The assertions check the control behaviour on every cycle:
- the reset state;
- the advance of the expected index and its freeze during preload;
- the error flag, raised for each wrong index and only then;
- the update strobe following an accepted sample;
- outputs holding still when their channel is untouched;
- the preload value and its priority over the adder.

Arithmetic results need the bench's scenarios. Only the reference model's sums show:
- the rounding of the scaled increment for negative samples;
- the recirculated value meeting the right channel after idle gaps, a rejected index and a mid-run reset;
- clamping at both ends of the range;
- a seed surviving into the next integration round.

// File: rtl/tmi_pkg.sv
package tmi_pkg;

  // Distance from position b forward to position a on a ring of n slots.
  function automatic int ring_dist(input int a, input int b, input int n);
    return (a + n - b) % n;
  endfunction

endpackage

// File: rtl/tmi_scale.sv
// Stage 1: order check, step multiplication, registered scaled increment.
module tmi_scale #(
  parameter int NCH       = 4,
  parameter int CH_W      = 2,
  parameter int IN_W      = 16,
  parameter int COEF_W    = 8,
  parameter int STEP_COEF = 20,
  parameter int STEP_FRAC = 4,
  parameter int PROD_W    = IN_W + COEF_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [CH_W-1:0]          in_chan,
  input  logic signed [IN_W-1:0]   in_data,
  input  logic                     hold,
  output logic                     s1_valid,
  output logic [CH_W-1:0]          s1_chan,
  output logic signed [PROD_W-1:0] s1_prod,
  output logic                     seq_err,
  output logic [CH_W-1:0]          exp_chan
);

  localparam logic signed [COEF_W-1:0] COEF_S = COEF_W'(STEP_COEF);
  localparam logic [CH_W-1:0]          LAST   = CH_W'(NCH - 1);

  logic signed [PROD_W-1:0] full_prod;
  logic                     take;
  logic                     wrong;

  assign full_prod = in_data * COEF_S;
  assign take      = in_valid && !hold && (in_chan == exp_chan);
  assign wrong     = in_valid && !hold && (in_chan != exp_chan);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_chan  <= '0;
      s1_prod  <= '0;
      seq_err  <= 1'b0;
      exp_chan <= '0;
    end else begin
      s1_valid <= take;
      seq_err  <= wrong;
      if (take) begin
        s1_chan  <= in_chan;
        s1_prod  <= full_prod >>> STEP_FRAC;
        exp_chan <= (exp_chan == LAST) ? '0 : exp_chan + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tmi_delay_line.sv
// Recirculating state: NCH words, head = oldest channel, tail takes new sums.
module tmi_delay_line #(
  parameter int NCH   = 4,
  parameter int CH_W  = 2,
  parameter int ACC_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    shift_en,
  input  logic signed [ACC_W-1:0] shift_din,
  input  logic                    pre_en,
  input  logic [CH_W-1:0]         pre_chan,
  input  logic signed [ACC_W-1:0] pre_data,
  output logic signed [ACC_W-1:0] head_q
);

  localparam logic [CH_W-1:0] LAST = CH_W'(NCH - 1);

  logic signed [ACC_W-1:0] line_q   [NCH];
  logic signed [ACC_W-1:0] line_nxt [NCH];
  logic [CH_W-1:0]         head_chan;
  logic [CH_W-1:0]         head_nxt;
  logic [CH_W-1:0]         pre_pos;

  assign head_nxt = !shift_en ? head_chan :
                    (head_chan == LAST) ? '0 : head_chan + 1'b1;

  // Slot of the preloaded channel once this cycle's shift is applied.
  assign pre_pos = CH_W'(tmi_pkg::ring_dist(int'(pre_chan), int'(head_nxt), NCH));

  for (genvar p = 0; p < NCH; p++) begin : g_slot
    logic signed [ACC_W-1:0] moved;
    if (p == NCH - 1) begin : g_tail
      assign moved = shift_din;
    end else begin : g_body
      assign moved = line_q[p+1];
    end
    assign line_nxt[p] = (pre_en && pre_pos == CH_W'(p)) ? pre_data :
                         shift_en                          ? moved    :
                                                             line_q[p];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_chan <= '0;
      for (int p = 0; p < NCH; p++) line_q[p] <= '0;
    end else begin
      head_chan <= head_nxt;
      for (int p = 0; p < NCH; p++) line_q[p] <= line_nxt[p];
    end
  end

  assign head_q = line_q[0];

endmodule

// File: rtl/tmi_accum.sv
// Stage 2: saturating add and per-channel output registers.
module tmi_accum #(
  parameter int NCH    = 4,
  parameter int CH_W   = 2,
  parameter int ACC_W  = 24,
  parameter int PROD_W = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     s1_valid,
  input  logic [CH_W-1:0]          s1_chan,
  input  logic signed [PROD_W-1:0] s1_prod,
  input  logic signed [ACC_W-1:0]  head_q,
  input  logic                     pre_en,
  input  logic [CH_W-1:0]          pre_chan,
  input  logic signed [ACC_W-1:0]  pre_data,
  output logic                     shift_en,
  output logic signed [ACC_W-1:0]  sum_sat,
  output logic [NCH-1:0][ACC_W-1:0] ch_out,
  output logic [NCH-1:0]           ch_upd
);

  localparam int EXT = ACC_W + 1 - PROD_W;
  localparam logic signed [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W:0]     head_x;
  logic signed [ACC_W:0]     prod_x;
  logic signed [ACC_W:0]     sum_w;
  logic [NCH-1:0][ACC_W-1:0] out_nxt;
  logic [NCH-1:0]            upd_nxt;

  assign shift_en = s1_valid;
  assign head_x   = {head_q[ACC_W-1], head_q};
  assign prod_x   = {{EXT{s1_prod[PROD_W-1]}}, s1_prod};
  assign sum_w    = head_x + prod_x;

  always_comb begin
    if (sum_w[ACC_W] != sum_w[ACC_W-1]) sum_sat = sum_w[ACC_W] ? MINV : MAXV;
    else                                sum_sat = sum_w[ACC_W-1:0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic hit_pre;
    logic hit_add;
    assign hit_pre    = pre_en && (pre_chan == CH_W'(i));
    assign hit_add    = s1_valid && (s1_chan == CH_W'(i));
    assign out_nxt[i] = hit_pre ? pre_data : hit_add ? sum_sat : ch_out[i];
    assign upd_nxt[i] = hit_add && !hit_pre;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_out <= '0;
      ch_upd <= '0;
    end else begin
      ch_out <= out_nxt;
      ch_upd <= upd_nxt;
    end
  end

endmodule

// File: rtl/tm_euler_integrator.sv
module tm_euler_integrator #(
  parameter int NCH       = 4,
  parameter int IN_W      = 16,
  parameter int COEF_W    = 8,
  parameter int STEP_COEF = 20,
  parameter int STEP_FRAC = 4,
  parameter int ACC_W     = 24,
  parameter int CH_W      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [CH_W-1:0]           in_chan,
  input  logic signed [IN_W-1:0]    in_data,
  input  logic                      preload_en,
  input  logic [CH_W-1:0]           preload_chan,
  input  logic signed [ACC_W-1:0]   preload_data,
  output logic [NCH-1:0][ACC_W-1:0] ch_out,
  output logic [NCH-1:0]            ch_upd,
  output logic                      seq_err
);

  localparam int PROD_W = IN_W + COEF_W;

  logic                     s1_valid;
  logic [CH_W-1:0]          s1_chan;
  logic signed [PROD_W-1:0] s1_prod;
  logic [CH_W-1:0]          exp_chan;
  logic                     shift_en;
  logic signed [ACC_W-1:0]  sum_sat;
  logic signed [ACC_W-1:0]  head_q;

  tmi_scale #(
    .NCH(NCH), .CH_W(CH_W), .IN_W(IN_W), .COEF_W(COEF_W),
    .STEP_COEF(STEP_COEF), .STEP_FRAC(STEP_FRAC), .PROD_W(PROD_W)
  ) u_scale (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
    .in_data(in_data), .hold(preload_en), .s1_valid(s1_valid),
    .s1_chan(s1_chan), .s1_prod(s1_prod), .seq_err(seq_err),
    .exp_chan(exp_chan)
  );

  tmi_delay_line #(.NCH(NCH), .CH_W(CH_W), .ACC_W(ACC_W)) u_line (
    .clk(clk), .rst(rst), .shift_en(shift_en), .shift_din(sum_sat),
    .pre_en(preload_en), .pre_chan(preload_chan), .pre_data(preload_data),
    .head_q(head_q)
  );

  tmi_accum #(.NCH(NCH), .CH_W(CH_W), .ACC_W(ACC_W), .PROD_W(PROD_W)) u_accum (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_chan(s1_chan),
    .s1_prod(s1_prod), .head_q(head_q), .pre_en(preload_en),
    .pre_chan(preload_chan), .pre_data(preload_data), .shift_en(shift_en),
    .sum_sat(sum_sat), .ch_out(ch_out), .ch_upd(ch_upd)
  );

endmodule

// File: rtl/tmi_integrator_chk.sv
module tmi_integrator_chk #(
  parameter int NCH   = 4,
  parameter int CH_W  = 2,
  parameter int ACC_W = 24
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      in_valid,
  input logic [CH_W-1:0]           in_chan,
  input logic                      preload_en,
  input logic [CH_W-1:0]           preload_chan,
  input logic [ACC_W-1:0]          preload_data,
  input logic [NCH-1:0][ACC_W-1:0] ch_out,
  input logic [NCH-1:0]            ch_upd,
  input logic                      seq_err,
  input logic [CH_W-1:0]           exp_chan,
  input logic                      s1_valid,
  input logic [CH_W-1:0]           s1_chan
);

  localparam logic [CH_W-1:0] LAST = CH_W'(NCH - 1);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (ch_out == '0 && ch_upd == '0 && !seq_err && exp_chan == '0));

  a_r2_index_advances: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !preload_en && in_chan == exp_chan) |=>
      exp_chan == (($past(exp_chan) == LAST) ? '0 : CH_W'($past(exp_chan) + 1'b1)));

  a_r2_idle_keeps_index: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(exp_chan));

  a_r5_upd_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_upd));

  a_r7_flag_wrong_index: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !preload_en && in_chan != exp_chan) |=> seq_err);

  a_r7_no_spurious_flag: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && !preload_en && in_chan != exp_chan) |=> !seq_err);

  a_r9_preload_freezes_index: assert property (@(posedge clk) disable iff (rst)
    preload_en |=> ($stable(exp_chan) && !seq_err));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    a_r4_strobe_follows: assert property (@(posedge clk) disable iff (rst)
      (s1_valid && s1_chan == CH_W'(i) && !(preload_en && preload_chan == CH_W'(i)))
        |=> ch_upd[i]);

    a_r5_hold_untouched: assert property (@(posedge clk) disable iff (rst)
      (!(s1_valid && s1_chan == CH_W'(i)) && !(preload_en && preload_chan == CH_W'(i)))
        |=> ($stable(ch_out[i]) && !ch_upd[i]));

    a_r8_preload_wins: assert property (@(posedge clk) disable iff (rst)
      (preload_en && preload_chan == CH_W'(i)) |=>
        (ch_out[i] == $past(preload_data) && !ch_upd[i]));
  end

endmodule

bind tm_euler_integrator tmi_integrator_chk #(
  .NCH(NCH), .CH_W(CH_W), .ACC_W(ACC_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
  .preload_en(preload_en), .preload_chan(preload_chan),
  .preload_data(preload_data), .ch_out(ch_out), .ch_upd(ch_upd),
  .seq_err(seq_err), .exp_chan(exp_chan), .s1_valid(s1_valid),
  .s1_chan(s1_chan)
);

// File: tb/tm_euler_integrator_bench.sv
module tm_euler_integrator_bench;

  localparam int  NCH  = 4;
  localparam int  CH_W = 2;
  localparam int  IN_W = 16;
  localparam int  ACC_W = 24;
  localparam longint MAXV = 64'sd8388607;
  localparam longint MINV = -64'sd8388608;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [CH_W-1:0] in_chan = '0;
  logic signed [IN_W-1:0] in_data = '0;
  logic preload_en = 1'b0;
  logic [CH_W-1:0] preload_chan = '0;
  logic signed [ACC_W-1:0] preload_data = '0;
  logic [NCH-1:0][ACC_W-1:0] ch_out;
  logic [NCH-1:0] ch_upd;
  logic seq_err;

  tm_euler_integrator u_tm_euler_integrator (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
    .in_data(in_data), .preload_en(preload_en), .preload_chan(preload_chan),
    .preload_data(preload_data), .ch_out(ch_out), .ch_upd(ch_upd),
    .seq_err(seq_err)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit started = 1'b0;
  bit done = 1'b0;
  string phase = "R1";

  // Behavioural reference: channel state, outputs, pending sample.
  longint st[NCH];
  longint eo[NCH];
  bit [NCH-1:0] eu;
  bit ee;
  int nxt;
  bit pv;
  int pc;
  longint pp;

  function automatic longint scale(input longint d);
    longint p = d * 20;
    longint q = p / 16;
    if (p < 0 && (p % 16) != 0) q = q - 1;
    return q;
  endfunction

  function automatic longint clamp(input longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint outv(input int i);
    return longint'($signed(ch_out[i]));
  endfunction

  always @(posedge clk) begin
    cycles++;
    started = 1'b1;
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin st[i] = 0; eo[i] = 0; end
      eu = '0; ee = 1'b0; nxt = 0; pv = 1'b0; pc = 0; pp = 0;
    end else begin
      eu = '0;
      if (pv) begin
        st[pc] = clamp(st[pc] + pp);
        eo[pc] = st[pc];
        eu[pc] = 1'b1;
      end
      if (preload_en) begin
        st[preload_chan] = longint'(preload_data);
        eo[preload_chan] = longint'(preload_data);
        eu[preload_chan] = 1'b0;
      end
      ee = in_valid && !preload_en && (int'(in_chan) != nxt);
      pv = in_valid && !preload_en && (int'(in_chan) == nxt);
      if (pv) begin
        pc = int'(in_chan);
        pp = scale(longint'(in_data));
        nxt = (nxt + 1) % NCH;
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      for (int i = 0; i < NCH; i++) chk({phase, " ch_out"}, outv(i), eo[i]);
      chk({phase, " ch_upd"}, longint'(ch_upd), longint'(eu));
      chk({phase, " seq_err"}, longint'(seq_err), longint'(ee));
    end
  end

  task automatic put(input bit v, input int ch, input int d);
    @(negedge clk);
    in_valid = v; in_chan = CH_W'(ch); in_data = IN_W'(d);
    preload_en = 1'b0;
  endtask

  task automatic pl(input int ch, input int val, input bit v, input int ich);
    @(negedge clk);
    preload_en = 1'b1; preload_chan = CH_W'(ch); preload_data = ACC_W'(val);
    in_valid = v; in_chan = CH_W'(ich); in_data = 16'sd999;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) put(1'b0, 0, 0);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 20000);
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    idle(1);
    for (int i = 0; i < NCH; i++) chk("R1 reset out", outv(i), 0);
    chk("R1 reset seq_err", longint'(seq_err), 0);

    // R3: rounding of the scaled increment
    phase = "R3";
    put(1, 0, 7); put(1, 1, -7); put(1, 2, 16); put(1, 3, -16);
    idle(3);
    chk("R3 pos", outv(0), 8);
    chk("R3 neg", outv(1), -9);
    chk("R3 exact", outv(2), 20);
    chk("R3 exact neg", outv(3), -20);

    // R4: back-to-back rounds
    phase = "R4";
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < NCH; c++) put(1, c, (c % 2 == 0) ? 100 : -40);
    idle(3);
    chk("R4 ch0", outv(0), 383);
    chk("R4 ch1", outv(1), -159);
    chk("R4 ch3", outv(3), -170);

    // R2: idle gaps keep the rotation
    phase = "R2";
    put(1, 0, 8); idle(1); put(1, 1, 8); idle(2); put(1, 2, 8); put(1, 3, 8);
    idle(3);
    chk("R2 ch0", outv(0), 393);
    chk("R2 ch1", outv(1), -149);

    // R7: wrong index is dropped and flagged once
    phase = "R7";
    put(1, 2, 500);
    put(0, 0, 0);
    chk("R7 flag", longint'(seq_err), 1);
    put(1, 0, 0);
    chk("R7 flag clears", longint'(seq_err), 0);
    idle(3);
    chk("R7 dropped", outv(2), 405);

    // R8 / R9: preload with a concurrent sample that is ignored
    phase = "R8";
    pl(2, 8388000, 1'b1, 1);
    put(0, 0, 0);
    chk("R8 preload value", outv(2), 8388000);
    chk("R9 no error", longint'(seq_err), 0);
    pl(3, -8388000, 1'b1, 2);
    put(1, 1, 0);
    put(0, 0, 0);
    chk("R9 index kept", longint'(seq_err), 0);

    // R6: clamping at both ends
    phase = "R6";
    put(1, 2, 1000); put(1, 3, -1000);
    idle(3);
    chk("R6 high", outv(2), 8388607);
    chk("R6 low", outv(3), -8388608);

    // R8: preload beats a same-channel add, seed survives
    phase = "R8";
    put(1, 0, 100);
    pl(0, 555, 1'b0, 0);
    idle(3);
    chk("R8 priority", outv(0), 555);
    put(1, 1, 0); put(1, 2, 0); put(1, 3, 0); put(1, 0, 16);
    idle(3);
    chk("R8 seed kept", outv(0), 575);
    chk("R5 held", outv(2), 8388607);

    // R1: reset in mid-run
    phase = "R1";
    put(1, 1, 50);
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
    idle(2);
    chk("R1 mid reset", outv(1), 0);
    put(1, 0, 16);
    idle(3);
    chk("R1 restart index", outv(0), 20);

    finish_run();
  end

endmodule